// File: doc/BRIEF.md
# Target Command-Phase Block Mover

This block sequences one block-move instruction for a controller that acts as a target on a SCSI bus. The instruction arrives as a start pulse with a phase field, a programmed byte count and a starting address. The block first checks that the controller holds the bus as a target. It then drives the three phase lines from the instruction. Bytes arrive from the bus side through a request/acknowledge handshake, and each one is written to a counter-driven address on the memory side.

In command phase the length is not taken on trust. The group code in the top three bits of the first command byte selects a descriptor length of 6, 10 or 12 bytes. That length replaces the programmed count. A vendor-keep input decides whether the two vendor-unique groups also get a fixed length. An unusable configuration ends the instruction with an illegal interrupt: a count of zero, or a controller that is not connected as a target. An attention request from the initiator ends the transfer early, and so does a parity error on a received byte. A disable input suppresses both of those halts.

The controller has four states. ST_IDLE waits for start. ST_CHECK verifies target status and the count. ST_CMD_HEAD takes the first command byte. ST_XFER moves the remaining bytes. The transitions are:

- IDLE→CHECK when start is seen.
- CHECK→IDLE (illegal) when the controller is not a target, or when a non-command count is zero.
- CHECK→CMD_HEAD when the phase is command.
- CHECK→XFER otherwise.
- CMD_HEAD→IDLE when the decoded length is zero (illegal), when a halt occurs, or when the length is one.
- CMD_HEAD→XFER when more bytes remain.
- XFER→IDLE on the last byte or on a halt.

Top module: `tgt_cmd_mover`

## Requirements
- R1: If is_target is low when the instruction is checked, the block ends with irq_illegal set. No phase line is driven and nothing is written to memory.
- R2: While byte_req is high, {phase_msg, phase_cd, phase_io} equals instr_phase bits [2:0] as latched at start. When the block is idle, all three phase lines are 0.
- R3: With instr_phase = 3'b010 (command), the group code is bits [7:5] of the first received byte. Group 0 gives 6 bytes in total, groups 1 and 2 give 10, and group 5 gives 12. The first byte counts toward the total.
- R4: In command phase with vendor_keep low, group 6 gives 6 bytes and group 7 gives 10 bytes.
- R5: In command phase, groups 3 and 4 use the programmed count. Groups 6 and 7 also use it when vendor_keep is high.
- R6: If the count that applies is zero, the block ends with irq_illegal and writes nothing. In command phase this is decided when the first byte is acknowledged.
- R7: Each acknowledged byte is written with mem_we. The byte goes to mem_data and the address goes to mem_addr. Addresses run from instr_addr upward by one per byte. After exactly the applicable count of bytes, done is set.
- R8: With halt_disable low, atn high in a transfer cycle ends the transfer and sets irq_atn. A parity_err that comes with an acknowledged byte ends the transfer and sets irq_parity, and that byte is still written. With halt_disable high, both are ignored.
- R9: After reset, busy, byte_req, mem_we, done, all interrupts and all phase lines are 0.
- R10: A start pulse while busy is ignored. The running transfer keeps its phase and its address sequence.
- R11: The completion flags hold until the next accepted start, and at most one of them is set at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an instruction (accepted in idle only) |
| instr_phase | input | 3 | Phase field: [2] message, [1] command/data, [0] in/out |
| instr_count | input | CNT_W | Programmed byte count |
| instr_addr | input | ADDR_W | Start address |
| is_target | input | 1 | Controller is connected as target |
| vendor_keep | input | 1 | Vendor-unique groups keep the programmed count |
| halt_disable | input | 1 | Ignore attention and parity errors |
| atn | input | 1 | Initiator attention request |
| parity_err | input | 1 | Parity error on the current byte |
| byte_ack | input | 1 | Bus byte present (handshake acknowledge) |
| byte_data | input | 8 | Received byte |
| byte_req | output | 1 | Block requests a byte |
| phase_msg | output | 1 | Message phase line |
| phase_cd | output | 1 | Command/data phase line |
| phase_io | output | 1 | In/out phase line |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Memory write address |
| mem_data | output | 8 | Memory write data |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | Transfer completed normally |
| irq_illegal | output | 1 | Illegal instruction (not target or zero count) |
| irq_atn | output | 1 | Halted on attention |
| irq_parity | output | 1 | Halted on parity error |

## Verification
The hardest case to reach is a command-phase zero count. The block must accept the first byte's handshake and then reject it without writing it. This only happens when the group code selects the programmed-count path and the programmed count is zero. The bench sweeps every group code with vendor_keep both low and high, and with programmed counts of zero and three, so both paths of the length decision are forced for every group. Halts are placed on a chosen byte index by raising atn or parity_err in the same cycle as that byte's acknowledge. A second start is also injected in the middle of a transfer.

// File: rtl/tgt_mover_pkg.sv
package tgt_mover_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CHECK,
        ST_CMD_HEAD,
        ST_XFER
    } mover_state_e;

    typedef enum logic [2:0] {
        END_NONE,
        END_DONE,
        END_ILLEGAL,
        END_ATN,
        END_PARITY
    } mover_end_e;

    localparam logic [2:0] PHASE_COMMAND = 3'b010;

    localparam int unsigned CDB_LEN_SHORT = 6;
    localparam int unsigned CDB_LEN_MID   = 10;
    localparam int unsigned CDB_LEN_LONG  = 12;

endpackage

// File: rtl/cdb_len_decode.sv
module cdb_len_decode
    import tgt_mover_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic [7:0]       head_byte,
    input  logic             vendor_keep,
    input  logic [CNT_W-1:0] prog_count,
    output logic [CNT_W-1:0] used_count,
    output logic             replaced
);

    localparam logic [CNT_W-1:0] LEN_S = CNT_W'(CDB_LEN_SHORT);
    localparam logic [CNT_W-1:0] LEN_M = CNT_W'(CDB_LEN_MID);
    localparam logic [CNT_W-1:0] LEN_L = CNT_W'(CDB_LEN_LONG);

    logic [2:0]       group_code;
    logic [CNT_W-1:0] table_len;

    assign group_code = head_byte[7:5];

    always_comb begin
        table_len = '0;
        replaced  = 1'b0;
        unique case (group_code)
            3'd0: begin
                table_len = LEN_S;
                replaced  = 1'b1;
            end
            3'd1, 3'd2: begin
                table_len = LEN_M;
                replaced  = 1'b1;
            end
            3'd5: begin
                table_len = LEN_L;
                replaced  = 1'b1;
            end
            3'd6: begin
                table_len = LEN_S;
                replaced  = !vendor_keep;
            end
            3'd7: begin
                table_len = LEN_M;
                replaced  = !vendor_keep;
            end
            default: begin
                table_len = '0;
                replaced  = 1'b0;
            end
        endcase
        used_count = replaced ? table_len : prog_count;
    end

endmodule

// File: rtl/tgt_mover_dp.sv
module tgt_mover_dp #(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              head_take,
    input  logic              step,
    input  logic [CNT_W-1:0]  instr_count,
    input  logic [ADDR_W-1:0] instr_addr,
    input  logic [CNT_W-1:0]  head_count,
    output logic [CNT_W-1:0]  count_q,
    output logic [ADDR_W-1:0] addr_q
);

    localparam logic [CNT_W-1:0]  CNT_ONE  = CNT_W'(1);
    localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
            addr_q  <= '0;
        end else if (load) begin
            count_q <= instr_count;
            addr_q  <= instr_addr;
        end else if (head_take) begin
            count_q <= head_count - CNT_ONE;
            addr_q  <= addr_q + ADDR_ONE;
        end else if (step) begin
            count_q <= count_q - CNT_ONE;
            addr_q  <= addr_q + ADDR_ONE;
        end
    end

    p_no_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> count_q != '0);

endmodule

// File: rtl/tgt_mover_ctrl.sv
module tgt_mover_ctrl
    import tgt_mover_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [2:0]       instr_phase,
    input  logic             is_target,
    input  logic             halt_disable,
    input  logic             atn,
    input  logic             parity_err,
    input  logic             byte_ack,
    input  logic [CNT_W-1:0] count_q,
    input  logic [CNT_W-1:0] head_count,
    output logic             load,
    output logic             head_take,
    output logic             step,
    output logic             byte_req,
    output logic [2:0]       phase_drv,
    output logic             busy,
    output logic             done,
    output logic             irq_illegal,
    output logic             irq_atn,
    output logic             irq_parity
);

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    mover_state_e state_q, state_d;
    mover_end_e   end_kind;
    logic [2:0]   phase_q;
    logic         halt_req;
    mover_end_e   halt_kind;

    assign halt_req  = !halt_disable && (atn || (byte_ack && parity_err));
    assign halt_kind = atn ? END_ATN : END_PARITY;

    // next state and end classification
    always_comb begin
        state_d  = state_q;
        end_kind = END_NONE;
        unique case (state_q)
            ST_IDLE: begin
                if (start) state_d = ST_CHECK;
            end
            ST_CHECK: begin
                if (!is_target) begin
                    state_d  = ST_IDLE;
                    end_kind = END_ILLEGAL;
                end else if (phase_q == PHASE_COMMAND) begin
                    state_d = ST_CMD_HEAD;
                end else if (count_q == '0) begin
                    state_d  = ST_IDLE;
                    end_kind = END_ILLEGAL;
                end else begin
                    state_d = ST_XFER;
                end
            end
            ST_CMD_HEAD: begin
                if (byte_ack && head_count == '0) begin
                    state_d  = ST_IDLE;
                    end_kind = END_ILLEGAL;
                end else if (halt_req) begin
                    state_d  = ST_IDLE;
                    end_kind = halt_kind;
                end else if (byte_ack && head_count == CNT_ONE) begin
                    state_d  = ST_IDLE;
                    end_kind = END_DONE;
                end else if (byte_ack) begin
                    state_d = ST_XFER;
                end
            end
            ST_XFER: begin
                if (halt_req) begin
                    state_d  = ST_IDLE;
                    end_kind = halt_kind;
                end else if (byte_ack && count_q == CNT_ONE) begin
                    state_d  = ST_IDLE;
                    end_kind = END_DONE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register and latched instruction fields
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            phase_q     <= '0;
            done        <= 1'b0;
            irq_illegal <= 1'b0;
            irq_atn     <= 1'b0;
            irq_parity  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (load) begin
                phase_q     <= instr_phase;
                done        <= 1'b0;
                irq_illegal <= 1'b0;
                irq_atn     <= 1'b0;
                irq_parity  <= 1'b0;
            end else begin
                unique case (end_kind)
                    END_DONE:    done        <= 1'b1;
                    END_ILLEGAL: irq_illegal <= 1'b1;
                    END_ATN:     irq_atn     <= 1'b1;
                    END_PARITY:  irq_parity  <= 1'b1;
                    default: ;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        load      = 1'b0;
        head_take = 1'b0;
        step      = 1'b0;
        byte_req  = 1'b0;
        phase_drv = '0;
        busy      = 1'b1;
        unique case (state_q)
            ST_IDLE: begin
                busy = 1'b0;
                load = start;
            end
            ST_CHECK: ;
            ST_CMD_HEAD: begin
                byte_req  = 1'b1;
                phase_drv = phase_q;
                head_take = byte_ack && (head_count != '0);
            end
            ST_XFER: begin
                byte_req  = 1'b1;
                phase_drv = phase_q;
                step      = byte_ack;
            end
            default: busy = 1'b0;
        endcase
    end

    p_hold_instr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> $stable(phase_q));

    p_one_outcome_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, irq_illegal, irq_atn, irq_parity}));

    p_atn_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_atn) |-> !$past(halt_disable));

    p_parity_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_parity) |-> !$past(halt_disable));

endmodule

// File: rtl/tgt_cmd_mover.sv
module tgt_cmd_mover
    import tgt_mover_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [2:0]        instr_phase,
    input  logic [CNT_W-1:0]  instr_count,
    input  logic [ADDR_W-1:0] instr_addr,
    input  logic              is_target,
    input  logic              vendor_keep,
    input  logic              halt_disable,
    input  logic              atn,
    input  logic              parity_err,
    input  logic              byte_ack,
    input  logic [7:0]        byte_data,
    output logic              byte_req,
    output logic              phase_msg,
    output logic              phase_cd,
    output logic              phase_io,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_data,
    output logic              busy,
    output logic              done,
    output logic              irq_illegal,
    output logic              irq_atn,
    output logic              irq_parity
);

    logic              load, head_take, step;
    logic [CNT_W-1:0]  count_q, head_count;
    logic [ADDR_W-1:0] addr_q;
    logic [2:0]        phase_drv;
    logic              replaced;

    cdb_len_decode #(.CNT_W(CNT_W)) u_decode (
        .head_byte  (byte_data),
        .vendor_keep(vendor_keep),
        .prog_count (count_q),
        .used_count (head_count),
        .replaced   (replaced)
    );

    tgt_mover_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .instr_phase (instr_phase),
        .is_target   (is_target),
        .halt_disable(halt_disable),
        .atn         (atn),
        .parity_err  (parity_err),
        .byte_ack    (byte_ack),
        .count_q     (count_q),
        .head_count  (head_count),
        .load        (load),
        .head_take   (head_take),
        .step        (step),
        .byte_req    (byte_req),
        .phase_drv   (phase_drv),
        .busy        (busy),
        .done        (done),
        .irq_illegal (irq_illegal),
        .irq_atn     (irq_atn),
        .irq_parity  (irq_parity)
    );

    tgt_mover_dp #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_dp (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .head_take  (head_take),
        .step       (step),
        .instr_count(instr_count),
        .instr_addr (instr_addr),
        .head_count (head_count),
        .count_q    (count_q),
        .addr_q     (addr_q)
    );

    assign {phase_msg, phase_cd, phase_io} = phase_drv;
    assign mem_we   = head_take | step;
    assign mem_addr = addr_q;
    assign mem_data = byte_data;

    p_idle_lines_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> ({phase_msg, phase_cd, phase_io} == 3'b000 && !mem_we));

    p_addr_advance_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> mem_addr == $past(mem_addr) + ADDR_W'(1));

    p_illegal_no_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_illegal) |-> !$past(mem_we));

    p_cmd_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (replaced && head_take) |-> (head_count == CNT_W'(6) ||
            head_count == CNT_W'(10) || head_count == CNT_W'(12)));

endmodule

// File: tb/test_tgt_cmd_mover.sv
`timescale 1ns/1ps
module test_tgt_cmd_mover;

    localparam int CNT_W  = 16;
    localparam int ADDR_W = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [2:0]        instr_phase = '0;
    logic [CNT_W-1:0]  instr_count = '0;
    logic [ADDR_W-1:0] instr_addr = '0;
    logic              is_target = 1'b0;
    logic              vendor_keep = 1'b0;
    logic              halt_disable = 1'b0;
    logic              atn = 1'b0;
    logic              parity_err = 1'b0;
    logic              byte_ack = 1'b0;
    logic [7:0]        byte_data = '0;
    logic              byte_req, phase_msg, phase_cd, phase_io, mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [7:0]        mem_data;
    logic              busy, done, irq_illegal, irq_atn, irq_parity;

    int tests = 0;
    int fails = 0;

    always #5 clk = ~clk;

    tgt_cmd_mover #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) i_tgt_cmd_mover (.*);

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // expected total length: R3, R4, R5
    function automatic int exp_len(input logic [2:0] ph, input int cnt,
                                   input logic [7:0] first, input bit vk);
        if (ph != 3'b010) return cnt;
        case (first[7:5])
            3'd0: return 6;
            3'd1, 3'd2: return 10;
            3'd5: return 12;
            3'd6: return vk ? cnt : 6;
            3'd7: return vk ? cnt : 10;
            default: return cnt;
        endcase
    endfunction

    // outcome codes: 0 done, 1 illegal, 2 atn, 3 parity
    task automatic run(input logic [2:0] ph, input int cnt, input logic [7:0] first,
                       input bit tgt, input bit vk, input bit hd, input int halt_at,
                       input bit use_par, input bit restart, input int exp_writes,
                       input int exp_end, input string req);
        int n = 0;
        int aerr = 0;
        int derr = 0;
        int perr = 0;
        logic [ADDR_W-1:0] base;
        logic [3:0] flags, eflags;
        base = ADDR_W'(16'h1200 + cnt * 3 + first);
        @(negedge clk);
        instr_phase = ph; instr_count = CNT_W'(cnt); instr_addr = base;
        is_target = tgt; vendor_keep = vk; halt_disable = hd;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int it = 0; it < 200; it++) begin
            if (!busy) break;
            byte_ack   = byte_req;
            byte_data  = (n == 0) ? first : 8'(8'h40 + n);
            atn        = byte_req && (n == halt_at) && !use_par;
            parity_err = byte_req && (n == halt_at) && use_par;
            start      = restart && (n == 1);
            if (restart && n == 1) instr_addr = 16'hBEEF;
            #1;
            if (byte_req && {phase_msg, phase_cd, phase_io} != ph) perr++;
            if (!tgt && {phase_msg, phase_cd, phase_io} != 3'b000) perr++;
            if (mem_we) begin
                if (mem_addr != base + ADDR_W'(n)) aerr++;
                if (mem_data != byte_data) derr++;
                n++;
            end
            @(negedge clk);
        end
        byte_ack = 0; atn = 0; parity_err = 0; start = 0;
        #1;
        check(n == exp_writes, {req, " write count"}, n, exp_writes);
        check(aerr == 0, "R7 address sequence", aerr, 0);
        check(derr == 0, "R7 write data", derr, 0);
        check(perr == 0, "R2 phase lines", perr, 0);
        flags  = {done, irq_illegal, irq_atn, irq_parity};
        eflags = 4'b1000 >> exp_end;
        check(flags == eflags, {req, " outcome flags"}, int'(flags), int'(eflags));
        check({phase_msg, phase_cd, phase_io} == 3'b000 && !busy, "R2 idle phase lines",
              int'({phase_msg, phase_cd, phase_io}), 0);
    endtask

    initial begin
        #(200000 * 10);
        fails++;
        tests++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        check(!busy && !byte_req && !mem_we, "R9 reset control", int'({busy, byte_req, mem_we}), 0);
        check({done, irq_illegal, irq_atn, irq_parity, phase_msg, phase_cd, phase_io} == 0,
              "R9 reset flags", int'({done, irq_illegal, irq_atn, irq_parity}), 0);
        rst_n = 1'b1;

        // R1 not connected as target
        run(3'b010, 4, 8'h00, 1'b0, 1'b0, 1'b0, -1, 1'b0, 1'b0, 0, 1, "R1");
        run(3'b000, 4, 8'h00, 1'b0, 1'b0, 1'b0, -1, 1'b0, 1'b0, 0, 1, "R1");

        // R3 R4 R5 R6: every group, vendor_keep both ways, counts 0 and 3
        for (int g = 0; g < 8; g++) begin
            for (int vk = 0; vk < 2; vk++) begin
                for (int c = 0; c < 4; c += 3) begin
                    logic [7:0] fb;
                    int el;
                    fb = 8'((g << 5) | 5'h0B);
                    el = exp_len(3'b010, c, fb, vk[0]);
                    run(3'b010, c, fb, 1'b1, vk[0], 1'b0, -1, 1'b0, 1'b0, el,
                        (el == 0) ? 1 : 0, (el == 0) ? "R6" : "R3/R4/R5");
                end
            end
        end

        // R7 R6 non-command phases with counts 0, 1, 4
        for (int p = 0; p < 8; p++) begin
            if (p == 2) continue;
            for (int c = 0; c < 5; c += (c == 1) ? 3 : 1) begin
                run(3'(p), c, 8'hA5, 1'b1, 1'b0, 1'b0, -1, 1'b0, 1'b0, c,
                    (c == 0) ? 1 : 0, (c == 0) ? "R6" : "R7");
            end
        end

        // R8 halts: attention and parity, enabled and disabled
        run(3'b000, 6, 8'h11, 1'b1, 1'b0, 1'b0, 2, 1'b0, 1'b0, 3, 2, "R8 atn");
        run(3'b001, 6, 8'h11, 1'b1, 1'b0, 1'b0, 2, 1'b1, 1'b0, 3, 3, "R8 parity");
        run(3'b000, 6, 8'h11, 1'b1, 1'b0, 1'b1, 2, 1'b0, 1'b0, 6, 0, "R8 atn disabled");
        run(3'b001, 6, 8'h11, 1'b1, 1'b0, 1'b1, 2, 1'b1, 1'b0, 6, 0, "R8 parity disabled");
        run(3'b010, 3, 8'h20, 1'b1, 1'b0, 1'b0, 0, 1'b0, 1'b0, 1, 2, "R8 atn on head");
        run(3'b010, 3, 8'hA0, 1'b1, 1'b0, 1'b0, 5, 1'b1, 1'b0, 6, 3, "R8 parity in cdb");

        // R10 start while busy ignored; R11 flags cleared by next start
        run(3'b000, 5, 8'h22, 1'b1, 1'b0, 1'b0, -1, 1'b0, 1'b1, 5, 0, "R10");
        run(3'b000, 0, 8'h22, 1'b1, 1'b0, 1'b0, -1, 1'b0, 1'b0, 0, 1, "R11");

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule